// File: doc/BRIEF.md
# Dual-Channel Compare Output Timer

This block is a 16-bit up-counter with two compare channels, A and B. Each channel holds a 16-bit compare value and a 2-bit action code. On a counter advance while the counter equals the channel's compare value, the channel applies its action to its own output line. The action is one of four: leave the line alone, invert it, force it low or force it high. Every such match also pulses a one-cycle event flag for that channel.

The counter advances only on cycles where the external prescale `tick` input is high and the run state machine is in `ST_RUN`. The state machine has two states. `ST_STOP` is the reset state. The `START` transition (clock-select field nonzero) moves it to `ST_RUN`. The `HALT` transition (clock-select field zero) returns it to `ST_STOP`. The state register follows the clock-select field, so a new clock-select value takes effect one cycle after it is written.

An optional clear-on-match bit makes the counter restart from zero after a channel A match, which gives a programmable period. A PWM enable bit freezes both output lines; the event flags keep pulsing. Software reaches eight byte-wide registers through a synchronous write port and a combinational read port.

Top module: `cmp_timer`

## Requirements
- R1: Address 0 is control byte A. Bits 7:6 hold channel A's action code, bits 5:4 hold channel B's action code, and bit 0 holds the PWM enable. All of these read back as written.
- R2: Bits 3:1 of control byte A ignore writes and always read 0.
- R3: Action code 00 leaves the channel's output line unchanged by matches.
- R4: Action code 01 inverts the channel's output line on every match.
- R5: Action code 10 drives the output line to 0 on a match, and action code 11 drives it to 1.
- R6: Address 1 is control byte B. Bit 3 is the clear-on-match enable and bits 2:0 are the clock-select field. Bits 7:4 ignore writes and read 0.
- R7: Reset clears every register, the counter, both output lines and both flags.
- R8: With clock select 000, the counter holds its value. With any nonzero clock select, the counter rises by one on each tick, starting one cycle after the write, and wraps from 0xFFFF to 0. The counter does not move on cycles without a tick.
- R9: A match is a counter advance while the counter equals a channel's compare value. With clear-on-match set, a channel A match loads 0 into the counter instead of the incremented value.
- R10: Each match makes that channel's flag output (`match_a`, `match_b`) 1 for exactly the following cycle, whatever the action code.
- R11: While PWM enable is 1, both output lines keep their values through matches, and the flags still pulse.
- R12: The byte registers are at these addresses: 2 and 3 hold compare A (low and high byte), 4 and 5 hold compare B, 6 and 7 hold the counter. A counter write takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescale enable; one counter advance per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| oc_a | output | 1 | Channel A output line |
| oc_b | output | 1 | Channel B output line |
| match_a | output | 1 | Channel A one-cycle match flag |
| match_b | output | 1 | Channel B one-cycle match flag |

## Verification
The assertions check the following on every cycle:
- the reserved bits of both control bytes read as zero;
- each action code's effect on its output line at a match;
- the flag pulse that follows each match;
- the frozen outputs under PWM enable;
- the counter holding in `ST_STOP`;
- the zero reload on a channel A match with clear-on-match set.

Other behaviour needs the bench's scenarios. These are the cumulative result of several periods with clear-on-match set, the toggle parity after many matches, wrap-around at 0xFFFF, the one-cycle delay of a clock-select change, and read-back of the register layout.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } cmp_act_t;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam int ADDR_W = 3;
    localparam int NUM_CH = 2;

    localparam logic [ADDR_W-1:0] A_CTRLA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRLB  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA_L = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPA_H = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMPB_L = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMPB_H = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT_L  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CNT_H  = 3'd7;

endpackage

// File: rtl/ct_regs.sv
module ct_regs
    import ct_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt,
    output cmp_act_t          mode_a,
    output cmp_act_t          mode_b,
    output logic              pwm_en,
    output logic              ctc_en,
    output logic [2:0]        clk_sel,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output logic              cnt_wr_lo,
    output logic              cnt_wr_hi
);

    // Write side: one byte lane per address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_a  <= ACT_OFF;
            mode_b  <= ACT_OFF;
            pwm_en  <= 1'b0;
            ctc_en  <= 1'b0;
            clk_sel <= 3'b000;
            cmp_a   <= '0;
            cmp_b   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRLA: begin
                    mode_a <= cmp_act_t'(wr_data[7:6]);
                    mode_b <= cmp_act_t'(wr_data[5:4]);
                    pwm_en <= wr_data[0];
                end
                A_CTRLB: begin
                    ctc_en  <= wr_data[3];
                    clk_sel <= wr_data[2:0];
                end
                A_CMPA_L: cmp_a[DATA_W-1:0]     <= wr_data;
                A_CMPA_H: cmp_a[CNT_W-1:DATA_W] <= wr_data;
                A_CMPB_L: cmp_b[DATA_W-1:0]     <= wr_data;
                A_CMPB_H: cmp_b[CNT_W-1:DATA_W] <= wr_data;
                A_CNT_L, A_CNT_H: ;
            endcase
        end
    end

    // Counter bytes live in the counter module; only strobes leave here
    always_comb begin
        cnt_wr_lo = wr_en && (wr_addr == A_CNT_L);
        cnt_wr_hi = wr_en && (wr_addr == A_CNT_H);
    end

    // Read side: reserved bits are constant zero
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRLA: begin
                rd_data[7:6] = mode_a;
                rd_data[5:4] = mode_b;
                rd_data[0]   = pwm_en;
            end
            A_CTRLB: begin
                rd_data[3]   = ctc_en;
                rd_data[2:0] = clk_sel;
            end
            A_CMPA_L: rd_data = cmp_a[DATA_W-1:0];
            A_CMPA_H: rd_data = cmp_a[CNT_W-1:DATA_W];
            A_CMPB_L: rd_data = cmp_b[DATA_W-1:0];
            A_CMPB_H: rd_data = cmp_b[CNT_W-1:DATA_W];
            A_CNT_L:  rd_data = cnt[DATA_W-1:0];
            A_CNT_H:  rd_data = cnt[CNT_W-1:DATA_W];
        endcase
    end

endmodule

// File: rtl/ct_count.sv
module ct_count
    import ct_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [2:0]        clk_sel,
    input  logic              ctc_en,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic              cnt_wr_lo,
    input  logic              cnt_wr_hi,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [CNT_W-1:0]  cnt,
    output logic [NUM_CH-1:0] hit,
    output run_state_t        run_state
);

    run_state_t run_next;
    logic       adv;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) run_state <= ST_STOP;
        else        run_state <= run_next;
    end

    // Transitions: START when a clock source is picked, HALT when none is
    always_comb begin
        run_next = run_state;
        unique case (run_state)
            ST_STOP: if (clk_sel != 3'b000) run_next = ST_RUN;
            ST_RUN:  if (clk_sel == 3'b000) run_next = ST_STOP;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        adv    = (run_state == ST_RUN) && tick;
        hit[0] = adv && (cnt == cmp_a);
        hit[1] = adv && (cnt == cmp_b);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_wr_lo || cnt_wr_hi) begin
            if (cnt_wr_lo) cnt[DATA_W-1:0]     <= wr_byte;
            if (cnt_wr_hi) cnt[CNT_W-1:DATA_W] <= wr_byte;
        end else if (adv) begin
            if (ctc_en && hit[0]) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ct_chan.sv
module ct_chan
    import ct_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit,
    input  cmp_act_t mode,
    input  logic     pwm_en,
    output logic     line,
    output logic     flag
);

    logic line_next;

    always_comb begin
        line_next = line;
        if (hit && !pwm_en) begin
            unique case (mode)
                ACT_OFF:    line_next = line;
                ACT_TOGGLE: line_next = ~line;
                ACT_LOW:    line_next = 1'b0;
                ACT_HIGH:   line_next = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= 1'b0;
            flag <= 1'b0;
        end else begin
            line <= line_next;
            flag <= hit;
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import ct_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              oc_a,
    output logic              oc_b,
    output logic              match_a,
    output logic              match_b
);

    cmp_act_t           mode_a, mode_b;
    logic               pwm_en, ctc_en;
    logic [2:0]         clk_sel;
    logic [CNT_W-1:0]   cmp_a, cmp_b, cnt;
    logic               cnt_wr_lo, cnt_wr_hi;
    logic [NUM_CH-1:0]  hit;
    run_state_t         run_state;
    cmp_act_t           mode_v [NUM_CH];
    logic [NUM_CH-1:0]  line_v, flag_v;

    ct_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt),
        .mode_a(mode_a), .mode_b(mode_b), .pwm_en(pwm_en), .ctc_en(ctc_en),
        .clk_sel(clk_sel), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi)
    );

    ct_count #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel),
        .ctc_en(ctc_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi), .wr_byte(wr_data),
        .cnt(cnt), .hit(hit), .run_state(run_state)
    );

    assign mode_v[0] = mode_a;
    assign mode_v[1] = mode_b;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ct_chan u_chan (
            .clk(clk), .rst_n(rst_n), .hit(hit[g]), .mode(mode_v[g]),
            .pwm_en(pwm_en), .line(line_v[g]), .flag(flag_v[g])
        );
    end

    assign oc_a    = line_v[0];
    assign oc_b    = line_v[1];
    assign match_a = flag_v[0];
    assign match_b = flag_v[1];

endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        mode_a,
    input logic [1:0]        mode_b,
    input logic              pwm_en,
    input logic              ctc_en,
    input logic              run_state,
    input logic [1:0]        hit,
    input logic              oc_a,
    input logic              oc_b,
    input logic              match_a,
    input logic              match_b,
    input logic [CNT_W-1:0]  cnt,
    input logic              cnt_wr_lo,
    input logic              cnt_wr_hi
);

    assert_ctrla_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd0) |-> (rd_data[3:1] == 3'b000));

    assert_ctrlb_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd1) |-> (rd_data[7:4] == 4'b0000));

    assert_off_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 2'b00) |=> $stable(oc_a));

    assert_off_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b == 2'b00) |=> $stable(oc_b));

    assert_toggle_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && mode_a == 2'b01 && !pwm_en) |=> (oc_a != $past(oc_a)));

    assert_toggle_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && mode_b == 2'b01 && !pwm_en) |=> (oc_b != $past(oc_b)));

    assert_low_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && mode_a == 2'b10 && !pwm_en) |=> !oc_a);

    assert_high_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && mode_a == 2'b11 && !pwm_en) |=> oc_a);

    assert_low_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && mode_b == 2'b10 && !pwm_en) |=> !oc_b);

    assert_high_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && mode_b == 2'b11 && !pwm_en) |=> oc_b);

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_state && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(cnt));

    assert_clear_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && ctc_en && !cnt_wr_lo && !cnt_wr_hi) |=> (cnt == '0));

    assert_flag_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> match_a);

    assert_flag_a_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[0] |=> !match_a);

    assert_flag_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> match_b);

    assert_flag_b_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[1] |=> !match_b);

    assert_pwm_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |=> ($stable(oc_a) && $stable(oc_b)));

endmodule

bind cmp_timer ct_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .mode_a(mode_a), .mode_b(mode_b), .pwm_en(pwm_en), .ctc_en(ctc_en),
    .run_state(run_state), .hit(hit), .oc_a(oc_a), .oc_b(oc_b),
    .match_a(match_a), .match_b(match_b), .cnt(cnt),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       oc_a, oc_b, match_a, match_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmp_timer u_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .oc_a(oc_a), .oc_b(oc_b),
        .match_a(match_a), .match_b(match_b)
    );

    // {mode_a, mode_b, clear_on_match, cmp_a, cmp_b, ticks, exp_oc_a, exp_oc_b, exp_cnt}
    localparam logic [38:0] VEC [7] = '{
        {2'b01, 2'b11, 1'b0, 8'd3, 8'd5, 8'd8, 1'b1, 1'b1, 8'd8},
        {2'b01, 2'b01, 1'b0, 8'd2, 8'd9, 8'd6, 1'b1, 1'b0, 8'd6},
        {2'b01, 2'b00, 1'b1, 8'd2, 8'd1, 8'd7, 1'b0, 1'b0, 8'd1},
        {2'b11, 2'b01, 1'b1, 8'd3, 8'd1, 8'd9, 1'b1, 1'b0, 8'd1},
        {2'b00, 2'b11, 1'b0, 8'd0, 8'd0, 8'd1, 1'b0, 1'b1, 8'd1},
        {2'b01, 2'b01, 1'b1, 8'd1, 8'd1, 8'd5, 1'b0, 1'b0, 8'd1},
        {2'b01, 2'b01, 1'b1, 8'd0, 8'd0, 8'd3, 1'b1, 1'b1, 8'd0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] d2;

        // R7: reset state
        do_reset();
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R7 register reset", {8'h0, d}, 16'h0);
        end
        check("R7 outputs reset", {12'h0, oc_a, oc_b, match_a, match_b}, 16'h0);

        // R1 R2: control byte A layout, reserved bits
        wr(3'd0, 8'hFF);
        rd(3'd0, d);
        check("R2 ctrl A reserved bits", {8'h0, d}, 16'h00F1);
        wr(3'd0, 8'h90);
        rd(3'd0, d);
        check("R1 ctrl A fields", {8'h0, d}, 16'h0090);
        // R6: control byte B layout
        wr(3'd1, 8'hFF);
        rd(3'd1, d);
        check("R6 ctrl B reserved bits", {8'h0, d}, 16'h000F);
        // R12: compare byte lanes
        wr(3'd3, 8'hA5);
        wr(3'd4, 8'h3C);
        rd(3'd3, d); rd(3'd4, d2);
        check("R12 compare byte lanes", {d, d2}, 16'hA53C);

        // Vector table: R3 R4 R5 R9 R8
        for (int v = 0; v < 7; v++) begin
            do_reset();
            wr(3'd2, VEC[v][33:26]);
            wr(3'd4, VEC[v][25:18]);
            wr(3'd0, {VEC[v][38:37], VEC[v][36:35], 4'b0000});
            wr(3'd1, {4'b0000, VEC[v][34], 3'b001});
            @(negedge clk);
            for (int t = 0; t < int'(VEC[v][17:10]); t++) pulse_tick();
            check($sformatf("R4 R5 R3 vector %0d line A", v), {15'h0, oc_a}, {15'h0, VEC[v][9]});
            check($sformatf("R4 R5 R3 vector %0d line B", v), {15'h0, oc_b}, {15'h0, VEC[v][8]});
            rd(3'd6, d);
            check($sformatf("R9 R8 vector %0d count", v), {8'h0, d}, {8'h0, VEC[v][7:0]});
        end

        // R5 R10: set then clear, flag width
        do_reset();
        wr(3'd0, 8'hC0);
        wr(3'd1, 8'h01);
        @(negedge clk);
        pulse_tick();
        check("R5 set on match", {15'h0, oc_a}, 16'h1);
        check("R10 flag after match", {15'h0, match_a}, 16'h1);
        @(negedge clk);
        check("R10 flag one cycle", {15'h0, match_a}, 16'h0);

        // R11: PWM freezes output, flag still pulses
        wr(3'd0, 8'h41);
        wr(3'd6, 8'h00);
        pulse_tick();
        check("R11 line frozen under PWM", {15'h0, oc_a}, 16'h1);
        check("R11 flag under PWM", {15'h0, match_a}, 16'h1);

        // R5: clear action
        wr(3'd0, 8'h80);
        wr(3'd6, 8'h00);
        pulse_tick();
        check("R5 clear on match", {15'h0, oc_a}, 16'h0);

        // R8: wrap at all ones
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        pulse_tick();
        rd(3'd6, d); rd(3'd7, d2);
        check("R8 wrap to zero", {d2, d}, 16'h0000);

        // R8: no tick, no advance
        repeat (3) @(negedge clk);
        rd(3'd6, d);
        check("R8 idle without tick", {8'h0, d}, 16'h0000);

        // R8: clock select zero stops counting
        wr(3'd1, 8'h00);
        @(negedge clk);
        repeat (3) pulse_tick();
        rd(3'd6, d);
        check("R8 stopped by clock select", {8'h0, d}, 16'h0000);

        // R12: counter write wins over a tick in the same cycle
        wr(3'd1, 8'h02);
        @(negedge clk);
        tick = 1'b1;
        wr(3'd6, 8'h40);
        tick = 1'b0;
        rd(3'd6, d);
        check("R12 write over advance", {8'h0, d}, 16'h0040);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule